// File: doc/BRIEF.md
# Write Enable and Block Protection Unit

This unit is the write gatekeeper of a small serial nonvolatile memory. It holds the one-bit write enable latch and the two-bit block-protect code. It takes the level of the hardware write-protect pin and the busy flag of the internal programming cycle. From these it builds the status byte that the serial front end shifts out. It also gives two permission signals. One says whether a write to the current target address may go ahead. The other says whether a status write may go ahead.

The serial command decoder in front of this unit turns completed, correctly framed instructions into single-cycle strobes. The enable-set strobe is raised only when chip select rises right after exactly eight instruction bits. Other strobes clear the latch and request a status write, and one reports that an array write cycle has finished. The array write controller asks about each byte of a page on its own, so a page that straddles a protected boundary keeps its open bytes writable and its locked bytes refused. The protect code is kept in registers with a reset value that models the factory setting. That value locks the top quarter of the array.

Top module: `wprot_unit`

## Requirements
- R1: After reset the status byte reads 0x04 while busy is low: latch clear, protect code 01 (bit 2 set, bit 3 clear).
- R2: Status layout is fixed: bit 0 is the busy input, bit 1 the enable latch, bit 2 the low protect bit, bit 3 the high protect bit, and bits 7:4 read as zero.
- R3: An enable-set strobe sets the latch on the next clock when the protect pin is high and busy is low, whatever the protect code.
- R4: An enable-clear strobe clears the latch on the next clock when busy is low. If set and clear arrive in the same cycle, clear wins.
- R5: On any clock edge where the protect pin is low, the latch becomes 0. This includes edges during a busy cycle and edges with an enable-set strobe. The busy bit keeps following the busy input.
- R6: A status-write strobe is accepted when the latch is 1, the pin is high and busy is low. Data bits 3:2 then load the protect code (bit 3 high, bit 2 low), the latch clears, and the other data bits have no effect.
- R7: A status-write strobe is refused when the latch is 0 or the pin is low. The protect code is then unchanged.
- R8: A write-done strobe clears the latch on the next clock.
- R9: The address-allow output is 1 only when the latch is 1, the pin is high, busy is low and the address lies outside the locked region. Locked regions by code: 00 none, 01 0xC0–0xFF, 10 0x80–0xFF, 11 the whole array.
- R10: The status-write-allow output equals latch AND pin-high AND not-busy.
- R11: While busy is high, set, clear and status-write strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-up) |
| wp_n_i | input | 1 | Write-protect pin level, low = protect |
| busy_i | input | 1 | Internal programming cycle in progress |
| wren_i | input | 1 | Enable-set strobe |
| wrdi_i | input | 1 | Enable-clear strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Status-write data byte |
| wr_done_i | input | 1 | Array write cycle finished strobe |
| addr_i | input | 8 | Target byte address for the write-allow query |
| status_o | output | 8 | Readable status byte |
| addr_wr_ok_o | output | 1 | Write to addr_i permitted |
| sr_wr_ok_o | output | 1 | Status write permitted |

## Verification
Some rules hold on every cycle and are checked by the embedded assertions. A low pin always clears the latch by the next edge. The protect code changes only after a cycle in which the latch was set, and a refused status write leaves the code unchanged. Busy freezes the latch against command strobes. Code 11 refuses every address. Other behaviour needs the bench's scenarios to show it: the exact boundary addresses of each locked region, the set-versus-clear collision, masking of the spare data bits, and a protect-pin drop during a busy cycle. A reference model compared on every clock covers the full status byte and both allow outputs.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
    localparam int STAT_W    = 8;
    localparam int STAT_BUSY = 0;
    localparam int STAT_WEL  = 1;
    localparam int STAT_BPL  = 2;
    localparam int STAT_BPH  = 3;

    typedef logic [1:0] bp_code_t;

    localparam bp_code_t BP_OPEN    = 2'b00;
    localparam bp_code_t BP_QUARTER = 2'b01;
    localparam bp_code_t BP_HALF    = 2'b10;
    localparam bp_code_t BP_ALL     = 2'b11;
endpackage

// File: rtl/wprot_enable_latch.sv
module wprot_enable_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wp_n_i,
    input  logic busy_i,
    input  logic set_i,
    input  logic clr_i,
    input  logic commit_i,
    input  logic done_i,
    output logic wel_o
);
    typedef struct packed {
        logic wel;
    } latch_t;

    latch_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!wp_n_i) begin
            st_d.wel = 1'b0;
        end else if (done_i) begin
            st_d.wel = 1'b0;
        end else if (!busy_i) begin
            if (clr_i || commit_i) begin
                st_d.wel = 1'b0;
            end else if (set_i) begin
                st_d.wel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wel_o = st_q.wel;

    p_wp_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> !wel_o);

    p_wren_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_n_i && !busy_i && !done_i && !clr_i && !commit_i && set_i) |=> wel_o);

    p_busy_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wp_n_i && !done_i) |=> $stable(wel_o));

    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !wel_o);
endmodule

// File: rtl/wprot_bp_store.sv
module wprot_bp_store
    import wprot_pkg::*;
#(
    parameter bp_code_t RESET_CODE = BP_QUARTER
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     commit_i,
    input  bp_code_t code_i,
    output bp_code_t code_o
);
    typedef struct packed {
        bp_code_t code;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            st_d.code = code_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= RESET_CODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
endmodule

// File: rtl/wprot_region_map.sv
module wprot_region_map
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  bp_code_t          code_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              locked_o
);
    localparam int TOP = ADDR_W - 1;

    logic in_half, in_quarter;

    generate
        if (ADDR_W >= 2) begin : g_wide
            assign in_half    = addr_i[TOP];
            assign in_quarter = addr_i[TOP] & addr_i[TOP-1];
        end else begin : g_narrow
            assign in_half    = addr_i[TOP];
            assign in_quarter = addr_i[TOP];
        end
    endgenerate

    always_comb begin
        unique case (code_i)
            BP_OPEN:    locked_o = 1'b0;
            BP_QUARTER: locked_o = in_quarter;
            BP_HALF:    locked_o = in_half;
            default:    locked_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
    import wprot_pkg::*;
#(
    parameter int       ADDR_W   = 8,
    parameter bp_code_t BP_RESET = BP_QUARTER
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp_n_i,
    input  logic              busy_i,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              wr_done_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              addr_wr_ok_o,
    output logic              sr_wr_ok_o
);
    localparam int SPARE_W = STAT_W - 4;

    logic     wel;
    logic     locked;
    logic     sr_ok;
    logic     commit;
    bp_code_t bp_code;
    bp_code_t bp_next;
    logic     unused_data;

    assign sr_ok       = wel & wp_n_i & ~busy_i;
    assign commit      = wrsr_i & sr_ok;
    assign bp_next     = {wrsr_data_i[STAT_BPH], wrsr_data_i[STAT_BPL]};
    assign unused_data = ^{wrsr_data_i[7:4], wrsr_data_i[1:0]};

    wprot_enable_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wp_n_i   (wp_n_i),
        .busy_i   (busy_i),
        .set_i    (wren_i),
        .clr_i    (wrdi_i),
        .commit_i (commit),
        .done_i   (wr_done_i),
        .wel_o    (wel)
    );

    wprot_bp_store #(.RESET_CODE(BP_RESET)) u_bp (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .code_i   (bp_next),
        .code_o   (bp_code)
    );

    wprot_region_map #(.ADDR_W(ADDR_W)) u_map (
        .code_i   (bp_code),
        .addr_i   (addr_i),
        .locked_o (locked)
    );

    always_comb begin
        status_o            = '0;
        status_o[STAT_BUSY] = busy_i;
        status_o[STAT_WEL]  = wel;
        status_o[STAT_BPL]  = bp_code[0];
        status_o[STAT_BPH]  = bp_code[1];
        status_o[STAT_W-1 -: SPARE_W] = '0;
    end

    assign sr_wr_ok_o   = sr_ok;
    assign addr_wr_ok_o = sr_ok & ~locked;

    p_bp_change_needs_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_code != $past(bp_code)) |-> $past(wel));

    p_refused_keeps_bp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_i && (!wel || !wp_n_i)) |=> $stable(bp_code));

    p_all_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_code == BP_ALL) |-> !addr_wr_ok_o);

    p_busy_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> (!sr_wr_ok_o && !addr_wr_ok_o));
endmodule

// File: tb/wprot_unit_test.sv
module wprot_unit_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wp_n_i = 1'b1;
    logic       busy_i = 1'b0;
    logic       wren_i = 1'b0;
    logic       wrdi_i = 1'b0;
    logic       wrsr_i = 1'b0;
    logic [7:0] wrsr_data_i = 8'h00;
    logic       wr_done_i = 1'b0;
    logic [7:0] addr_i = 8'h00;
    logic [7:0] status_o;
    logic       addr_wr_ok_o;
    logic       sr_wr_ok_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    bit model_on = 1'b0;

    int m_wel = 0;
    int m_bp = 1;

    always #5 clk = ~clk;

    wprot_unit uut (
        .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n_i), .busy_i(busy_i),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
        .wrsr_data_i(wrsr_data_i), .wr_done_i(wr_done_i), .addr_i(addr_i),
        .status_o(status_o), .addr_wr_ok_o(addr_wr_ok_o), .sr_wr_ok_o(sr_wr_ok_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_locked(input int bp, input int a);
        case (bp)
            0: return 0;
            1: return (a >= 192) ? 1 : 0;
            2: return (a >= 128) ? 1 : 0;
            default: return 1;
        endcase
    endfunction

    function automatic int m_status();
        return (m_bp * 4) + (m_wel * 2) + (busy_i ? 1 : 0);
    endfunction

    function automatic int m_sr_ok();
        return (m_wel == 1 && wp_n_i && !busy_i) ? 1 : 0;
    endfunction

    // Per-cycle comparison against the reference model, then state update
    task automatic step();
        int acc;
        #1;
        if (model_on) begin
            chk("R2 status", status_o, m_status());
            chk("R10 sr_ok", sr_wr_ok_o, m_sr_ok());
            chk("R9 addr_ok", addr_wr_ok_o,
                (m_sr_ok() == 1 && m_locked(m_bp, addr_i) == 0) ? 1 : 0);
        end
        @(posedge clk);
        acc = (wrsr_i && m_sr_ok() == 1) ? 1 : 0;
        if (acc == 1) m_bp = (wrsr_data_i >> 2) & 3;
        if (!wp_n_i) m_wel = 0;
        else if (wr_done_i) m_wel = 0;
        else if (!busy_i) begin
            if (wrdi_i || acc == 1) m_wel = 0;
            else if (wren_i) m_wel = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wren_i = 0; wrdi_i = 0; wrsr_i = 0; wr_done_i = 0; wrsr_data_i = 8'h00;
    endtask

    task automatic do_wren();
        wren_i = 1; step(); idle();
    endtask

    task automatic do_wrsr(input logic [7:0] d);
        wrsr_i = 1; wrsr_data_i = d; step(); idle();
    endtask

    task automatic probe(input string tag, input logic [7:0] a, input int exp);
        addr_i = a; #1;
        chk(tag, addr_wr_ok_o, exp);
        step();
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        model_on = 1'b1;
        #1;
        chk("R1 reset status", status_o, 8'h04);
        chk("R1 reset sr_ok", sr_wr_ok_o, 0);
        step();

        // R3: set latch with default protection
        do_wren();
        #1 chk("R3 wel set", status_o, 8'h06);
        probe("R9 q 0x00", 8'h00, 1);
        probe("R9 q 0xBF", 8'hBF, 1);
        probe("R9 q 0xC0", 8'hC0, 0);
        probe("R9 q 0xFF", 8'hFF, 0);

        // R4: set and clear together, clear wins
        wren_i = 1; wrdi_i = 1; step(); idle();
        #1 chk("R4 clear wins", status_o, 8'h04);
        do_wren();
        wrdi_i = 1; step(); idle();
        #1 chk("R4 wrdi clears", status_o, 8'h04);

        // R6: accepted status write, spare bits masked
        do_wren();
        do_wrsr(8'hFB);
        #1 chk("R6 bp=10 wel clr", status_o, 8'h08);
        do_wren();
        probe("R9 h 0x7F", 8'h7F, 1);
        probe("R9 h 0x80", 8'h80, 0);

        // R9/R10: everything locked, status still writable
        do_wrsr(8'h0C);
        #1 chk("R6 bp=11", status_o, 8'h0C);
        do_wren();
        #1 chk("R10 sr ok", sr_wr_ok_o, 1);
        probe("R9 all 0x00", 8'h00, 0);
        probe("R9 all 0x55", 8'h55, 0);

        // R7: refused status writes
        wrdi_i = 1; step(); idle();
        do_wrsr(8'h00);
        #1 chk("R7 wel0 refused", status_o, 8'h0C);
        do_wren();
        wp_n_i = 0; wrsr_i = 1; wrsr_data_i = 8'h00; step(); idle();
        #1 chk("R7 wp low refused", status_o, 8'h0C);
        // R5: wp low beats set strobe
        wren_i = 1; step(); idle();
        #1 chk("R5 wp low keeps wel 0", status_o, 8'h0C);
        #1 chk("R10 wp low sr", sr_wr_ok_o, 0);
        wp_n_i = 1; step();

        // R11: busy freezes latch
        do_wren();
        busy_i = 1;
        wrdi_i = 1; step(); idle();
        #1 chk("R11 busy ignores wrdi", status_o, 8'h0F);
        wrsr_i = 1; wrsr_data_i = 8'h00; step(); idle();
        #1 chk("R11 busy ignores wrsr", status_o, 8'h0F);
        chk("R10 busy sr", sr_wr_ok_o, 0);
        // R5: wp drop during busy clears latch, busy still reported
        wp_n_i = 0; step(); wp_n_i = 1;
        #1 chk("R5 wp during busy", status_o, 8'h0D);
        wren_i = 1; step(); idle();
        #1 chk("R11 busy ignores wren", status_o, 8'h0D);
        busy_i = 0; step();
        do_wren();
        busy_i = 1; step();
        // R8: write done clears latch
        wr_done_i = 1; step(); idle(); busy_i = 0;
        #1 chk("R8 done clears", status_o, 8'h0C);

        // open map
        do_wren();
        do_wrsr(8'hF3);
        #1 chk("R6 bp=00", status_o, 8'h00);
        do_wren();
        probe("R9 open 0xFF", 8'hFF, 1);
        probe("R9 open 0xC0", 8'hC0, 1);
        do_wrsr(8'h04);
        do_wren();
        probe("R9 q2 0xFA", 8'hFA, 0);
        repeat (4) step();
        finish_run();
    end
endmodule